// File: doc/BRIEF.md
# Strided Framebuffer Scanout Reader

The block reads a raster image out of shared main memory and presents it to a display pipeline as one 32-bit RGB value per pixel slot. It runs its own raster counters (active area, horizontal and vertical blanking). It issues word read requests on a memory port and stores the returned words in a small prefetch FIFO. The FIFO's content is drained one word per active pixel slot.

Image geometry is fixed by parameters. The image origin is byte address 0x07400000. Each line begins 0x1000 bytes after the previous one. A line's first pixel lies four 32-bit words past the line origin, and each pixel uses one word and skips the next, so pixel addresses advance by 8 bytes. The default visible area is 320 x 240.

The request side is valid/ready. Once the block raises a request, it holds the request and its word address unchanged until the memory accepts it. Back-pressure on the request channel only slows fetching. The response side has no ready: the memory returns exactly one word per accepted request, in request order, with a one-cycle data-valid strobe. The block never has more words requested or stored than the FIFO can hold, so it can always accept a response. The pixel output has no ready either, because raster timing cannot stall. If the FIFO is empty in an active slot, the block flags an underflow.

Top module: `fb_scanout`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no request is raised and pix_valid, pix_sof, pix_eol and pix_underflow are all low.
- R2: pix_valid is high for H_ACT consecutive cycles per line. Lines within a frame are separated by exactly H_BLANK idle cycles. Consecutive frames are separated by H_BLANK + V_BLANK*(H_ACT+H_BLANK) idle cycles.
- R3: Requests are issued in raster order. Pixel x of line y uses word address BASE_BYTE/4 + y*(PITCH_BYTES/4) + LINE_OFS_WORDS + PIX_STRIDE_WORDS*x, which with the defaults is 0x01D00000 + 1024*y + 4 + 2*x.
- R4: Each non-underflow pixel on pix_data equals, bit for bit, the word returned for that pixel's address, in raster order.
- R5: pix_sof is high exactly with pixel (0,0) of each frame. pix_eol is high exactly with the last pixel (x = H_ACT-1) of each line.
- R6: While mem_req_valid is high and mem_req_ready is low, both mem_req_valid and mem_req_addr hold their values into the next cycle.
- R7: The count of words stored in the FIFO plus requests not yet answered never exceeds FIFO_DEPTH. With no responses returning and ready always high, exactly FIFO_DEPTH requests are issued and then mem_req_valid drops.
- R8: An active slot with an empty FIFO gives pix_underflow = 1 and pix_data = 0. The late word for that slot is discarded when it arrives, so the pixels that follow stay aligned. If memory keeps pace, no underflow occurs.
- R9: The first request for line n+1 is issued before that line's first pixel is output, i.e. during line n or its blanking.
- R10: Every frame is fetched again from the image origin. When vertical blanking begins, the FIFO is flushed and any unanswered requests are discarded, so each frame starts aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | AW | 32-bit word address of the request |
| mem_rsp_valid | input | 1 | Returned data valid, one per accepted request, in order |
| mem_rsp_data | input | 32 | Returned word |
| pix_valid | output | 1 | Active pixel slot |
| pix_data | output | 32 | RGB pixel value (0 on underflow) |
| pix_sof | output | 1 | First pixel of a frame |
| pix_eol | output | 1 | Last pixel of a line |
| pix_underflow | output | 1 | Active slot found the FIFO empty |

## Verification
The assertions assume that the memory returns a word only while at least one accepted request is unanswered, and that responses come back in the order of acceptance. The bench's memory model meets this with a queue: each accepted address is pushed at acceptance and popped only after a configurable latency. The model also throttles ready with periodic stall cycles. In the latency and stall settings used by the bench, one line's fetches complete well within a line period. The only starvation is the deliberate response freeze in the underflow test.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  typedef logic [31:0] pixel_t;

  // raster position flags for the current clock
  typedef struct packed {
    logic active;
    logic first;
    logic last;
  } slot_t;
endpackage

// File: rtl/fb_raster.sv
module fb_raster
  import fb_scan_pkg::*;
#(
  parameter int H_ACT   = 320,
  parameter int H_BLANK = 80,
  parameter int V_ACT   = 240,
  parameter int V_BLANK = 20
) (
  input  logic  clk,
  input  logic  rst_n,
  output slot_t slot,
  output logic  restart
);
  localparam int H_TOT = H_ACT + H_BLANK;
  localparam int V_TOT = V_ACT + V_BLANK;
  localparam int HW = $clog2(H_TOT);
  localparam int VW = $clog2(V_TOT);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);

  logic [HW-1:0] h;
  logic [VW-1:0] v;

  // leave reset at the top of vertical blanking so line 0 can be prefetched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h <= '0;
      v <= VW'(V_ACT);
    end else if (h == H_LAST) begin
      h <= '0;
      v <= (v == V_LAST) ? '0 : v + 1'b1;
    end else begin
      h <= h + 1'b1;
    end
  end

  assign slot.active = (h < HW'(H_ACT)) && (v < VW'(V_ACT));
  assign slot.first  = slot.active && (h == '0) && (v == '0);
  assign slot.last   = slot.active && (h == HW'(H_ACT - 1));
  assign restart     = (h == H_LAST) && (v == VW'(V_ACT - 1));
endmodule

// File: rtl/fb_fifo.sv
module fb_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr,
  input  logic [DW-1:0]                wdata,
  input  logic                         rd,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (wr) wp <= (wp == P_LAST) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == P_LAST) ? '0 : rp + 1'b1;
      count <= count + CW'(wr) - CW'(rd);
    end
  end

  assign rdata = mem[rp];
  assign empty = (count == '0);
endmodule

// File: rtl/fb_fetch.sv
module fb_fetch #(
  parameter int AW      = 30,
  parameter int H_ACT   = 320,
  parameter int V_ACT   = 240,
  parameter int BASE_W  = 32'h01D0_0000,
  parameter int PITCH_W = 1024,
  parameter int OFS_W   = 4,
  parameter int STEP_W  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          credit_ok,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr
);
  localparam int XW = (H_ACT > 1) ? $clog2(H_ACT) : 1;
  localparam int YW = (V_ACT > 1) ? $clog2(V_ACT) : 1;
  localparam logic [AW-1:0] ORIGIN = AW'(BASE_W);
  localparam logic [AW-1:0] FIRST  = AW'(BASE_W + OFS_W);
  localparam logic [XW-1:0] X_LAST = XW'(H_ACT - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(V_ACT - 1);

  logic          busy, pend;
  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic [AW-1:0] line_base, addr;
  logic          hold, fire;

  assign req_valid = busy && credit_ok;
  assign req_addr  = addr;
  assign hold      = req_valid && !req_ready;
  assign fire      = req_valid && req_ready;

  // a restart that meets a pending request waits until it is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b1;
      x <= '0;
      y <= '0;
      line_base <= ORIGIN;
      addr <= FIRST;
    end else if ((restart || pend) && !hold) begin
      busy <= 1'b1;
      pend <= 1'b0;
      x <= '0;
      y <= '0;
      line_base <= ORIGIN;
      addr <= FIRST;
    end else begin
      if (restart) pend <= 1'b1;
      if (fire) begin
        if (x == X_LAST) begin
          x <= '0;
          line_base <= line_base + AW'(PITCH_W);
          addr <= line_base + AW'(PITCH_W) + AW'(OFS_W);
          if (y == Y_LAST) begin
            y <= '0;
            busy <= 1'b0;
          end else begin
            y <= y + 1'b1;
          end
        end else begin
          x <= x + 1'b1;
          addr <= addr + AW'(STEP_W);
        end
      end
    end
  end
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
  import fb_scan_pkg::*;
#(
  parameter int H_ACT            = 320,
  parameter int H_BLANK          = 80,
  parameter int V_ACT            = 240,
  parameter int V_BLANK          = 20,
  parameter int FIFO_DEPTH       = 16,
  parameter int AW               = 30,
  parameter int BASE_BYTE        = 32'h0740_0000,
  parameter int PITCH_BYTES      = 4096,
  parameter int LINE_OFS_WORDS   = 4,
  parameter int PIX_STRIDE_WORDS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          pix_valid,
  output logic [31:0]   pix_data,
  output logic          pix_sof,
  output logic          pix_eol,
  output logic          pix_underflow
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int SW = $clog2(H_ACT * V_ACT + FIFO_DEPTH + 1);

  slot_t         slot;
  logic          restart;
  logic          credit_ok;
  logic          fire;
  logic          under;
  logic          fifo_wr, fifo_rd, fifo_empty;
  pixel_t        fifo_rdata;
  logic [CW-1:0] fifo_cnt;
  logic [CW-1:0] outst;
  logic [SW-1:0] skip;
  logic          dec;
  logic [CW:0]   reserved;

  fb_raster #(.H_ACT(H_ACT), .H_BLANK(H_BLANK), .V_ACT(V_ACT), .V_BLANK(V_BLANK)) u_raster (
    .clk(clk), .rst_n(rst_n), .slot(slot), .restart(restart)
  );

  fb_fetch #(
    .AW(AW), .H_ACT(H_ACT), .V_ACT(V_ACT), .BASE_W(BASE_BYTE / 4),
    .PITCH_W(PITCH_BYTES / 4), .OFS_W(LINE_OFS_WORDS), .STEP_W(PIX_STRIDE_WORDS)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .restart(restart), .credit_ok(credit_ok),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr)
  );

  fb_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(restart), .wr(fifo_wr), .wdata(mem_rsp_data),
    .rd(fifo_rd), .rdata(fifo_rdata), .count(fifo_cnt), .empty(fifo_empty)
  );

  assign fire      = mem_req_valid && mem_req_ready;
  assign reserved  = {1'b0, fifo_cnt} + {1'b0, outst};
  assign credit_ok = reserved < (CW+1)'(FIFO_DEPTH);
  assign under     = slot.active && fifo_empty;
  assign fifo_rd   = slot.active && !fifo_empty;
  // a word owed to a slot that already went out is dropped, not stored
  assign dec       = mem_rsp_valid && ((skip != '0) || under);
  assign fifo_wr   = mem_rsp_valid && (skip == '0) && !under && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst <= '0;
      skip  <= '0;
    end else begin
      outst <= outst + CW'(fire) - CW'(mem_rsp_valid);
      if (restart)
        skip <= SW'(outst) + SW'(mem_req_valid) - SW'(mem_rsp_valid);
      else
        skip <= skip + SW'(under) - SW'(dec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid     <= 1'b0;
      pix_sof       <= 1'b0;
      pix_eol       <= 1'b0;
      pix_underflow <= 1'b0;
      pix_data      <= '0;
    end else begin
      pix_valid     <= slot.active;
      pix_sof       <= slot.first;
      pix_eol       <= slot.last;
      pix_underflow <= under;
      pix_data      <= fifo_rd ? fifo_rdata : '0;
    end
  end
endmodule

// File: rtl/fb_scanout_chk.sv
module fb_scanout_chk #(
  parameter int AW    = 30,
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          pix_valid,
  input logic [31:0]   pix_data,
  input logic          pix_sof,
  input logic          pix_eol,
  input logic          pix_underflow,
  input logic [CW-1:0] fifo_cnt,
  input logic [CW-1:0] outst,
  input logic          fifo_wr,
  input logic          fifo_rd
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && (fifo_cnt == CW'(DEPTH))) |-> fifo_rd); // R7

  AST_RESERVE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, fifo_cnt} + {1'b0, outst}) <= (CW+1)'(DEPTH))); // R7

  AST_RSP_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (outst != '0)); // R4

  AST_SOF_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof |-> pix_valid); // R5

  AST_EOL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eol |-> pix_valid); // R5

  AST_UNDERFLOW_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    pix_underflow |-> (pix_valid && (pix_data == '0))); // R8
endmodule

bind fb_scanout fb_scanout_chk #(.AW(AW), .CW(CW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .pix_valid(pix_valid),
  .pix_data(pix_data), .pix_sof(pix_sof), .pix_eol(pix_eol), .pix_underflow(pix_underflow),
  .fifo_cnt(fifo_cnt), .outst(outst), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd)
);

// File: tb/fb_scanout_tb.sv
module fb_scanout_tb;
  localparam int H_ACT = 8, H_BLANK = 6, V_ACT = 3, V_BLANK = 2, DEPTH = 16;
  localparam int H_TOT = H_ACT + H_BLANK;
  localparam int FRAME_PIX = H_ACT * V_ACT;
  localparam logic [29:0] BASE_W = 30'h01D0_0000;
  localparam int PITCH_W = 1024;
  localparam int WD_LIMIT = 50000;
  // each entry: {response latency, ready period (0 = always ready)}
  localparam logic [7:0] CFG [0:3] = '{8'h10, 8'h34, 8'h23, 8'h45};

  logic clk = 1'b0;
  logic rst_n;
  logic mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic mem_req_valid, pix_valid, pix_sof, pix_eol, pix_underflow;
  logic [29:0] mem_req_addr;
  logic [31:0] pix_data;

  always #5 clk = ~clk;

  fb_scanout #(.H_ACT(H_ACT), .H_BLANK(H_BLANK), .V_ACT(V_ACT), .V_BLANK(V_BLANK),
               .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .pix_underflow(pix_underflow)
  );

  // stimulus controls, written only by the main initial block
  int lat, per;
  bit rsp_en, chk_req, allow_uf;

  // monitor state, written only by the negedge block
  int cyc = 0;
  int wp, rp, px, py, gap, rx, ry, n_req, n_pix, uf_cnt, m_tot = 0, m_bad = 0;
  bit gap_ok, prev_hold;
  logic [29:0] prev_addr;
  logic [29:0] qa [0:63];
  int qd [0:63];
  int lrc [0:V_ACT-1];

  int i_tot = 0, i_bad = 0, wd = 0;

  function automatic logic [29:0] exp_addr(int x, int y);
    return BASE_W + 30'(y * PITCH_W + 4 + 2 * x);
  endfunction

  task automatic chk_m(bit ok, string tag, longint act, longint expv);
    m_tot++;
    if (!ok) begin
      m_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic chk_i(bit ok, string tag, longint act, longint expv);
    i_tot++;
    if (!ok) begin
      i_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      wp = 0; rp = 0; px = 0; py = 0; gap = 0; rx = 0; ry = 0;
      n_req = 0; n_pix = 0; uf_cnt = 0; gap_ok = 0; prev_hold = 0;
      for (int k = 0; k < V_ACT; k++) lrc[k] = -1;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data = '0;
    end else begin
      // R6: a stalled request is still there, unchanged
      if (prev_hold)
        chk_m(mem_req_valid && (mem_req_addr == prev_addr), "R6 request held",
              longint'(mem_req_addr), longint'(prev_addr));
      if (pix_valid) begin
        if (gap_ok) begin
          int eg;
          eg = (px != 0) ? 0 : ((py != 0) ? H_BLANK : H_BLANK + V_BLANK * H_TOT);
          chk_m(gap == eg, "R2 idle gap", gap, eg);
        end
        gap_ok = 1; gap = 0;
        chk_m(pix_sof == (px == 0 && py == 0), "R5 sof marker", pix_sof, (px == 0 && py == 0));
        chk_m(pix_eol == (px == H_ACT - 1), "R5 eol marker", pix_eol, (px == H_ACT - 1));
        if (pix_underflow) begin
          uf_cnt++;
          if (!allow_uf) chk_m(0, "R8 unexpected underflow", 1, 0);
          chk_m(pix_data == 32'h0, "R8 underflow data", pix_data, 0);
        end else begin
          chk_m(pix_data == {2'b10, exp_addr(px, py)}, "R4 pixel data",
                pix_data, {2'b10, exp_addr(px, py)});
        end
        if (chk_req && px == 0 && py > 0) begin
          chk_m(lrc[py] >= 0 && lrc[py] < cyc, "R9 line prefetched early", lrc[py], cyc);
          lrc[py] = -1;
        end
        n_pix++;
        if (px == H_ACT - 1) begin
          px = 0;
          py = (py == V_ACT - 1) ? 0 : py + 1;
        end else px++;
      end else gap++;

      mem_req_ready = (per == 0) || ((cyc % per) != 0);
      prev_hold = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (chk_req)
          chk_m(mem_req_addr == exp_addr(rx, ry), "R3 request address",
                longint'(mem_req_addr), longint'(exp_addr(rx, ry)));
        if (rx == 0) lrc[ry] = cyc;
        qa[wp % 64] = mem_req_addr;
        qd[wp % 64] = cyc + lat;
        wp++; n_req++;
        if (rx == H_ACT - 1) begin
          rx = 0;
          ry = (ry == V_ACT - 1) ? 0 : ry + 1;
        end else rx++;
      end
      if (rsp_en && rp != wp && qd[rp % 64] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = {2'b10, qa[rp % 64]};
        rp++;
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; lat = 1; per = 0; rsp_en = 1; chk_req = 1; allow_uf = 0;
    fork
      begin
        repeat (4) @(posedge clk);
        #2;
        chk_i(mem_req_valid == 1'b0, "R1 no request in reset", mem_req_valid, 0);
        chk_i(!pix_valid && !pix_sof && !pix_eol && !pix_underflow, "R1 outputs idle in reset",
              {pix_valid, pix_sof, pix_eol, pix_underflow}, 0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk_i(!pix_valid && !pix_underflow, "R1 idle after release",
              {pix_valid, pix_underflow}, 0);

        // table of memory behaviours, each run for about three frames
        for (int i = 0; i < 4; i++) begin
          lat = int'(CFG[i][7:4]);
          per = int'(CFG[i][3:0]);
          do_reset();
          repeat (220) @(posedge clk);
          #2;
          chk_i(n_pix >= 2 * FRAME_PIX, "R10 frames repeat", n_pix, 2 * FRAME_PIX);
          chk_i(uf_cnt == 0, "R8 no underflow when memory keeps pace", uf_cnt, 0);
        end

        // R7: responses withheld, reservations stop at the FIFO depth
        lat = 1; per = 0; rsp_en = 0;
        do_reset();
        repeat (24) @(posedge clk);
        #2;
        chk_i(n_req == DEPTH, "R7 request count capped", n_req, DEPTH);
        chk_i(mem_req_valid == 1'b0, "R7 request withheld at cap", mem_req_valid, 0);

        // R8: starve the FIFO mid-frame, then check flag, realignment and recovery
        rsp_en = 1; chk_req = 0; allow_uf = 1;
        do_reset();
        while (n_pix < 1) @(posedge clk);
        #2 rsp_en = 0;
        repeat (30) @(posedge clk);
        #2 rsp_en = 1;
        repeat (150) @(posedge clk);
        #2;
        chk_i(uf_cnt > 0, "R8 underflow flagged", uf_cnt, 1);
        begin
          int u0;
          u0 = uf_cnt;
          repeat (140) @(posedge clk);
          #2;
          chk_i(uf_cnt == u0, "R8 recovered after resync", uf_cnt, u0);
        end
      end
      begin
        repeat (WD_LIMIT) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd != 0) $display("FAIL watchdog expired actual=%0d expected=0", wd);
    $display("test done: total=%0d bad=%0d", m_tot + i_tot + wd, m_bad + i_bad + wd);
    $finish;
  end
endmodule